// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block sits behind the analog front end of a 100 Mb/s twisted-pair receiver. Each cycle of the 125 MHz recovered symbol clock it takes one sliced three-level line sample. It turns level changes into NRZI and then into NRZ bits. It removes the scrambler sequence and finds code-group boundaries at the start-of-stream delimiter. The 5-bit code groups it decodes come out as 4-bit nibbles on an MII-style receive interface, together with a data-valid flag and an error flag.

The descrambler synchronises itself. While unlocked, it assumes that the line carries idle (all-ones plaintext), so each received bit reveals one keystream bit. It loads those bits into its register and counts how many in a row agree with the register's own prediction. After `LOCK_RUN` agreements it locks, and from then on it runs freely. The nibble interface advances on a one-cycle strobe that fires every fifth symbol clock. The detection of a start delimiter re-phases that strobe.

Top module: `fe_rx_symdec`

## Requirements
- R1: While reset is held and right after it, `locked`, `mii_ce`, `rx_dv`, `rx_er` and `rxd` are all 0.
- R2: Any change of `line_lvl` between consecutive samples (encoding 00 zero, 01 positive, 10 negative) is a received 1, and an unchanged level is a 0. This comes from toggling an internal NRZI level and taking its transitions.
- R3: The keystream follows x^11 + x^9 + 1 (each bit is the XOR of the bits 11 and 9 positions earlier). Lock is declared after `LOCK_RUN` consecutive received bits that match idle, and it then stays set until reset.
- R4: While `locked` is 0, `rx_dv` stays 0.
- R5: A locked, out-of-frame stream whose last ten bits are 11111 then 11000 (idle, then the first delimiter group) starts a frame. The block strobes at once with `rxd`=0101 and `rx_dv`=1, and groups are aligned from the next bit. If the next group is 10001, it also gives 0101.
- R6: In a frame, data groups decode to nibbles 0..F from 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, sent most significant bit first.
- R7: The end group 01101 drops `rx_dv` at its strobe (with `rxd`=0, `rx_er`=0). The group after it produces no nibble.
- R8: In a frame, any other group that is not listed gives a nibble with `rx_dv`=1, `rx_er`=1 and `rxd`=0, and the frame continues.
- R9: An idle group 11111 in a frame, or a second group that is not 10001, gives one error nibble as in R8 and ends the frame. `rx_dv` is 0 from the next strobe.
- R10: `mii_ce` is a one-cycle pulse. Within a frame, consecutive strobes are 5 cycles apart, and `rxd`, `rx_dv` and `rx_er` change only in a cycle where `mii_ce` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | 2 | Sliced line level: 00 zero, 01 positive, 10 negative |
| locked | output | 1 | Descrambler locked |
| mii_ce | output | 1 | Nibble strobe, one cycle in five |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| rxd | output | 4 | Received nibble |

## Verification
The embedded properties check these rules on every cycle:
- `rx_dv` is never set without lock.
- Lock never falls.
- An error nibble always carries `rx_dv` and a zero value.
- The receive outputs move only with the strobe.
- Strobes never come back to back within a frame.

The bench scenarios cover what the properties cannot see. A scrambled stream is built with an arbitrary keystream seed, and the bench checks the exact nibble sequence, including the preamble substitution, every data code and the error and abort cases. It also checks the five-cycle strobe spacing inside frames and the lock timing against the idle run length.

// File: rtl/fe_rx_symdec.sv
module fe_rx_symdec #(
  parameter int LOCK_RUN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_lvl,
  output logic       locked,
  output logic       mii_ce,
  output logic       rx_dv,
  output logic       rx_er,
  output logic [3:0] rxd
);
  localparam int CNT_W = $clog2(LOCK_RUN + 1);
  localparam logic [4:0] GRP_K    = 5'b10001;
  localparam logic [4:0] GRP_T    = 5'b01101;
  localparam logic [4:0] GRP_IDLE = 5'b11111;
  localparam logic [9:0] SOS_PAT  = 10'b11111_11000;

  logic [1:0]       lvl_q;
  logic             nrzi_q;
  logic [10:0]      key;
  logic [CNT_W-1:0] run;
  logic [9:0]       win;
  logic [2:0]       ph;
  logic             in_frame, want_k;

  function automatic logic [4:0] dec5(input logic [4:0] g);
    case (g)
      5'b11110: dec5 = 5'h10; 5'b01001: dec5 = 5'h11;
      5'b10100: dec5 = 5'h12; 5'b10101: dec5 = 5'h13;
      5'b01010: dec5 = 5'h14; 5'b01011: dec5 = 5'h15;
      5'b01110: dec5 = 5'h16; 5'b01111: dec5 = 5'h17;
      5'b10010: dec5 = 5'h18; 5'b10011: dec5 = 5'h19;
      5'b10110: dec5 = 5'h1A; 5'b10111: dec5 = 5'h1B;
      5'b11010: dec5 = 5'h1C; 5'b11011: dec5 = 5'h1D;
      5'b11100: dec5 = 5'h1E; 5'b11101: dec5 = 5'h1F;
      default:  dec5 = 5'h00;
    endcase
  endfunction

  wire       mlt_chg = (line_lvl != lvl_q);
  wire       nrzi_d  = nrzi_q ^ mlt_chg;
  wire       nrz     = nrzi_d ^ nrzi_q;
  wire       pred    = key[10] ^ key[8];
  wire       plain   = nrz ^ pred;
  wire [9:0] win_d   = {win[8:0], plain};
  wire [4:0] grp     = win_d[4:0];
  wire [4:0] dec     = dec5(grp);
  wire       j_hit   = locked && !in_frame && (win_d == SOS_PAT);
  wire       grp_end = (ph == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0; nrzi_q <= 1'b0; key <= '0; run <= '0; locked <= 1'b0;
      win <= '0; ph <= '0; in_frame <= 1'b0; want_k <= 1'b0;
      mii_ce <= 1'b0; rx_dv <= 1'b0; rx_er <= 1'b0; rxd <= '0;
    end else begin
      lvl_q  <= line_lvl;
      nrzi_q <= nrzi_d;
      win    <= win_d;
      mii_ce <= 1'b0;
      if (!locked) begin
        key <= {key[9:0], ~nrz};
        if (~nrz == pred) begin
          run <= run + 1'b1;
          if (run == CNT_W'(LOCK_RUN - 1)) locked <= 1'b1;
        end else run <= '0;
      end else key <= {key[9:0], pred};

      if (j_hit) begin
        ph <= '0; mii_ce <= 1'b1; in_frame <= 1'b1; want_k <= 1'b1;
        rx_dv <= 1'b1; rx_er <= 1'b0; rxd <= 4'b0101;
      end else begin
        ph <= grp_end ? 3'd0 : ph + 3'd1;
        if (grp_end) begin
          mii_ce <= 1'b1;
          if (!in_frame) begin
            rx_dv <= 1'b0; rx_er <= 1'b0; rxd <= '0;
          end else if (want_k) begin
            want_k <= 1'b0;
            rx_dv  <= 1'b1;
            if (grp == GRP_K) begin
              rx_er <= 1'b0; rxd <= 4'b0101;
            end else begin
              rx_er <= 1'b1; rxd <= '0; in_frame <= 1'b0;
            end
          end else if (grp == GRP_T) begin
            rx_dv <= 1'b0; rx_er <= 1'b0; rxd <= '0; in_frame <= 1'b0;
          end else if (grp == GRP_IDLE) begin
            rx_dv <= 1'b1; rx_er <= 1'b1; rxd <= '0; in_frame <= 1'b0;
          end else if (dec[4]) begin
            rx_dv <= 1'b1; rx_er <= 1'b0; rxd <= dec[3:0];
          end else begin
            rx_dv <= 1'b1; rx_er <= 1'b1; rxd <= '0;
          end
        end
      end
    end
  end

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r4_no_dv_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !rx_dv);
  a_r8_err_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> (rx_dv && rxd == 4'd0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_ce |-> $stable({rx_dv, rx_er, rxd}));
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_ce && rx_dv) |=> !mii_ce);
endmodule

// File: tb/fe_rx_symdec_tb_top.sv
`timescale 1ns/1ps
module fe_rx_symdec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_lvl = 2'b00;
  wire        locked, mii_ce, rx_dv, rx_er;
  wire  [3:0] rxd;

  int checks = 0, fails = 0, cyc = 0, mlt_st = 0, last_ce = 0;
  logic [10:0] scr = 11'h5A3;
  int exp_q[$];
  logic last_dv = 1'b0;
  bit done = 1'b0;

  localparam int END_MARK = 32;

  fe_rx_symdec dut_i (.clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .locked(locked),
                      .mii_ce(mii_ce), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(int n);
    case (n)
      0: enc = 5'b11110; 1: enc = 5'b01001; 2: enc = 5'b10100; 3: enc = 5'b10101;
      4: enc = 5'b01010; 5: enc = 5'b01011; 6: enc = 5'b01110; 7: enc = 5'b01111;
      8: enc = 5'b10010; 9: enc = 5'b10011; 10: enc = 5'b10110; 11: enc = 5'b10111;
      12: enc = 5'b11010; 13: enc = 5'b11011; 14: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic send_bit(bit d);
    bit s, c;
    s = scr[10] ^ scr[8];
    scr = {scr[9:0], s};
    c = d ^ s;
    if (c) mlt_st = (mlt_st + 1) % 4;
    line_lvl = (mlt_st == 1) ? 2'b01 : (mlt_st == 3) ? 2'b10 : 2'b00;
    @(negedge clk);
  endtask

  task automatic send_grp(logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic idle(int n);
    repeat (n) send_bit(1'b1);
  endtask

  task automatic data(int n);
    exp_q.push_back(n);
    send_grp(enc(n));
  endtask

  task automatic start_jk();
    exp_q.push_back(5); send_grp(5'b11000);
    exp_q.push_back(5); send_grp(5'b10001);
  endtask

  task automatic end_tr();
    exp_q.push_back(END_MARK);
    send_grp(5'b01101);
    send_grp(5'b00111);
  endtask

  // Reference: every strobe inside or closing a frame pops one expected nibble
  always @(negedge clk) begin
    if (rst_n && mii_ce) begin
      if (rx_dv || last_dv) begin
        int code, e;
        code = rx_dv ? {27'd0, rx_er, rxd} : END_MARK;
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected nibble", code, -1);
        else begin
          e = exp_q.pop_front();
          if (e == END_MARK)  check(code == e, "R7 R9 frame end", code, e);
          else if (e >= 16)   check(code == e, "R8 R9 error nibble", code, e);
          else                check(code == e, "R2 R5 R6 nibble", code, e);
        end
        if (last_dv) check(cyc - last_ce == 5, "R10 strobe spacing", cyc - last_ce, 5);
      end
      last_dv = rx_dv;
      last_ce = cyc;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({locked, mii_ce, rx_dv, rx_er, rxd} == 8'd0, "R1 reset outputs",
          {locked, mii_ce, rx_dv, rx_er, rxd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({locked, rx_dv, rx_er, rxd} == 7'd0, "R1 after release", {locked, rx_dv, rx_er, rxd}, 0);
    // R4: a start pattern before lock must not open a frame
    idle(12); send_grp(5'b11000); send_grp(5'b10001);
    check(locked == 1'b0, "R3 not yet locked", locked, 0);
    check(rx_dv == 1'b0, "R4 no dv before lock", rx_dv, 0);
    idle(120);
    check(locked == 1'b1, "R3 locked after idle run", locked, 1);
    // Frame 1: every data code, R6
    start_jk();
    for (int n = 0; n < 16; n++) data(n);
    end_tr();
    idle(25);
    check(rx_dv == 1'b0, "R7 dv low after end", rx_dv, 0);
    // Frame 2: invalid group mid-frame, R8
    start_jk();
    data(10); data(3);
    exp_q.push_back(16); send_grp(5'b00100);
    data(7);
    end_tr();
    idle(25);
    // Frame 3: idle inside frame, R9
    start_jk();
    data(1); data(2);
    exp_q.push_back(16); exp_q.push_back(END_MARK);
    idle(30);
    check(rx_dv == 1'b0, "R9 frame ended by idle", rx_dv, 0);
    // Frame 4: start group not followed by the second delimiter, R9
    exp_q.push_back(5); send_grp(5'b11000);
    exp_q.push_back(16); exp_q.push_back(END_MARK);
    idle(30);
    check(rx_dv == 1'b0, "R9 abort without second delimiter", rx_dv, 0);
    check(locked == 1'b1, "R3 lock held", locked, 1);
    check(exp_q.size() == 0, "R7 all expected nibbles seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10 watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule